// File: doc/BRIEF.md
# Performance counter access port

This block is the access front end that stands between a register bus and a bank of performance counters. Each general-purpose counter is reachable through two write addresses with different width rules. The narrow legacy address accepts 32 bits and extends bit 31 upward. The full-width address stores the value as given, or refuses it when it does not fit. Fixed-function counters have their own address range and their own width. A read can also arrive as an encoded index word. One flag in that word picks the fixed group, another asks for a fast 32-bit result, and the low bits name the counter.

Every request is answered one clock later from registers. A write raises a one-hot strobe for the target counter and presents the shaped data on a shared data bus. A read returns the value masked to its counter's width. A request that cannot be honoured raises `fault` and produces neither a strobe nor read data. The counter storage lives outside the block and is presented to it as packed value buses.

Top module: `ctr_access_port`

## Requirements
- R1: A write to address group 2'b00 (`req_addr[7:6]`, counter number in `req_addr[5:0]`) stores `req_wdata[31:0]` with bit 31 copied into every bit from 32 up to GP_W-1.
- R2: A write to address group 2'b01 whose data has no bit set at or above GP_W strobes that counter with the data unchanged.
- R3: A write to group 2'b01 whose data has any bit set at or above GP_W raises `fault` and strobes no counter, so the stored value is unchanged.
- R4: A read of group 2'b00 or 2'b01 for the same counter returns the same stored value, masked to GP_W bits.
- R5: Group 2'b10 addresses the fixed counters. Writes there are masked to FX_W bits without a fault, and reads are masked to FX_W bits.
- R6: A read with `req_by_index` high decodes `req_index`. Bit 30 selects the fixed group (1) or the general-purpose group (0), and bits 29:0 give the counter number.
- R7: When bit 31 of `req_index` is set, the read returns only the low 32 bits of the counter, with the upper 32 bits zero.
- R8: A request that names a counter that does not exist raises `fault` with `rd_valid` low, `rd_data` zero and no strobe. This covers a number at or above NUM_GP or NUM_FX in either form, index 64, and address group 2'b11.
- R9: Responses appear on the clock edge after the request. At most one write strobe is high at a time. A cycle without `req_valid` gives no strobe, no `rd_valid` and no `fault` on the next cycle.
- R10: While `rst` is high, all strobes, `rd_valid`, `fault`, `wr_data` and `rd_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_by_index | input | 1 | For reads: decode `req_index` instead of `req_addr` |
| req_addr | input | 8 | Group in bits 7:6, counter number in bits 5:0 |
| req_index | input | 32 | Encoded read index word |
| req_wdata | input | 64 | Write data |
| gp_values | input | NUM_GP*GP_W | Current general-purpose counter values, counter 0 lowest |
| fx_values | input | NUM_FX*FX_W | Current fixed counter values, counter 0 lowest |
| gp_wr_en | output | NUM_GP | One-hot write strobe for the general-purpose counters |
| fx_wr_en | output | NUM_FX | One-hot write strobe for the fixed counters |
| wr_data | output | 64 | Shaped write data, valid with a strobe |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 64 | Read data |
| fault | output | 1 | Request refused |

## Verification
The assertions assume that `req_valid` is never high while `rst` is high. They also assume that the value buses only change through the strobes this block issues. The bench keeps to both: its counter bank model updates only on the strobes it observes, and it raises requests only after reset has been released. The sign-extension property also assumes that `req_by_index` has no meaning on writes. For that reason the bench drives it low on every write.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int CAP_DW = 64;
  localparam int CAP_NUMW = 6;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_WR_LEG,
    OP_WR_FULL,
    OP_WR_FX,
    OP_RD
  } cap_op_e;

  typedef struct packed {
    cap_op_e               op;
    logic                  grp_fx;
    logic                  fast;
    logic                  exists;
    logic [CAP_NUMW-1:0]   num;
  } cap_req_t;
endpackage

// File: rtl/cap_decode.sv
module cap_decode import cap_pkg::*; #(
  parameter int NUM_GP = 4,
  parameter int NUM_FX = 3
) (
  input  logic         req_valid,
  input  logic         req_write,
  input  logic         req_by_index,
  input  logic [7:0]   req_addr,
  input  logic [31:0]  req_index,
  output cap_req_t     dec
);
  always_comb begin
    dec = '0;
    dec.op = OP_NONE;
    if (req_valid) begin
      if (!req_write && req_by_index) begin
        dec.op     = OP_RD;
        dec.grp_fx = req_index[30];
        dec.fast   = req_index[31];
        dec.num    = req_index[CAP_NUMW-1:0];
        dec.exists = req_index[30] ? (req_index[29:0] < 30'(NUM_FX))
                                   : (req_index[29:0] < 30'(NUM_GP));
      end else begin
        dec.num = req_addr[CAP_NUMW-1:0];
        unique case (req_addr[7:6])
          2'b00: begin
            dec.op     = req_write ? OP_WR_LEG : OP_RD;
            dec.exists = req_addr[5:0] < 6'(NUM_GP);
          end
          2'b01: begin
            dec.op     = req_write ? OP_WR_FULL : OP_RD;
            dec.exists = req_addr[5:0] < 6'(NUM_GP);
          end
          2'b10: begin
            dec.op     = req_write ? OP_WR_FX : OP_RD;
            dec.grp_fx = 1'b1;
            dec.exists = req_addr[5:0] < 6'(NUM_FX);
          end
          default: begin
            dec.op     = req_write ? OP_WR_LEG : OP_RD;
            dec.exists = 1'b0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/cap_wshape.sv
module cap_wshape import cap_pkg::*; #(
  parameter int GP_W = 48,
  parameter int FX_W = 40
) (
  input  cap_op_e            op,
  input  logic [CAP_DW-1:0]  wdata,
  output logic [CAP_DW-1:0]  shaped,
  output logic               too_wide
);
  localparam logic [CAP_DW-1:0] GP_MASK =
    (GP_W >= CAP_DW) ? '1 : ((CAP_DW'(1) << GP_W) - CAP_DW'(1));
  localparam logic [CAP_DW-1:0] FX_MASK =
    (FX_W >= CAP_DW) ? '1 : ((CAP_DW'(1) << FX_W) - CAP_DW'(1));

  logic [CAP_DW-1:0] sext;
  assign sext = {{(CAP_DW-32){wdata[31]}}, wdata[31:0]};

  always_comb begin
    shaped   = '0;
    too_wide = 1'b0;
    unique case (op)
      OP_WR_LEG:  shaped = sext & GP_MASK;
      OP_WR_FULL: begin
        shaped   = wdata & GP_MASK;
        too_wide = |(wdata & ~GP_MASK);
      end
      OP_WR_FX:   shaped = wdata & FX_MASK;
      default:    shaped = '0;
    endcase
  end
endmodule

// File: rtl/cap_rsel.sv
module cap_rsel import cap_pkg::*; #(
  parameter int NUM_GP = 4,
  parameter int NUM_FX = 3,
  parameter int GP_W   = 48,
  parameter int FX_W   = 40
) (
  input  logic                    grp_fx,
  input  logic                    fast,
  input  logic [CAP_NUMW-1:0]     num,
  input  logic [NUM_GP*GP_W-1:0]  gp_values,
  input  logic [NUM_FX*FX_W-1:0]  fx_values,
  output logic [CAP_DW-1:0]       value
);
  logic [CAP_DW-1:0] gp_arr [NUM_GP];
  logic [CAP_DW-1:0] fx_arr [NUM_FX];
  logic [CAP_DW-1:0] picked;

  for (genvar g = 0; g < NUM_GP; g++) begin : g_gp
    assign gp_arr[g] = CAP_DW'(gp_values[g*GP_W +: GP_W]);
  end
  for (genvar f = 0; f < NUM_FX; f++) begin : g_fx
    assign fx_arr[f] = CAP_DW'(fx_values[f*FX_W +: FX_W]);
  end

  always_comb begin
    picked = '0;
    if (grp_fx) begin
      for (int i = 0; i < NUM_FX; i++)
        if (num == CAP_NUMW'(i)) picked = fx_arr[i];
    end else begin
      for (int i = 0; i < NUM_GP; i++)
        if (num == CAP_NUMW'(i)) picked = gp_arr[i];
    end
    value = fast ? {32'd0, picked[31:0]} : picked;
  end
endmodule

// File: rtl/ctr_access_port.sv
module ctr_access_port import cap_pkg::*; #(
  parameter int NUM_GP = 4,
  parameter int NUM_FX = 3,
  parameter int GP_W   = 48,
  parameter int FX_W   = 40
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic                    req_by_index,
  input  logic [7:0]              req_addr,
  input  logic [31:0]             req_index,
  input  logic [63:0]             req_wdata,
  input  logic [NUM_GP*GP_W-1:0]  gp_values,
  input  logic [NUM_FX*FX_W-1:0]  fx_values,
  output logic [NUM_GP-1:0]       gp_wr_en,
  output logic [NUM_FX-1:0]       fx_wr_en,
  output logic [63:0]             wr_data,
  output logic                    rd_valid,
  output logic [63:0]             rd_data,
  output logic                    fault
);
  cap_req_t          dec;
  logic [CAP_DW-1:0] shaped;
  logic              too_wide;
  logic [CAP_DW-1:0] rvalue;

  cap_decode #(.NUM_GP(NUM_GP), .NUM_FX(NUM_FX)) u_dec (
    .req_valid(req_valid), .req_write(req_write), .req_by_index(req_by_index),
    .req_addr(req_addr), .req_index(req_index), .dec(dec)
  );

  cap_wshape #(.GP_W(GP_W), .FX_W(FX_W)) u_wsh (
    .op(dec.op), .wdata(req_wdata), .shaped(shaped), .too_wide(too_wide)
  );

  cap_rsel #(.NUM_GP(NUM_GP), .NUM_FX(NUM_FX), .GP_W(GP_W), .FX_W(FX_W)) u_rsel (
    .grp_fx(dec.grp_fx), .fast(dec.fast), .num(dec.num),
    .gp_values(gp_values), .fx_values(fx_values), .value(rvalue)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gp_wr_en <= '0;
      fx_wr_en <= '0;
      wr_data  <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      fault    <= 1'b0;
    end else begin
      gp_wr_en <= '0;
      fx_wr_en <= '0;
      wr_data  <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      fault    <= 1'b0;
      if (dec.op != OP_NONE) begin
        if (!dec.exists || too_wide) begin
          fault <= 1'b1;
        end else if (dec.op == OP_RD) begin
          rd_valid <= 1'b1;
          rd_data  <= rvalue;
        end else begin
          wr_data <= shaped;
          if (dec.grp_fx) begin
            for (int i = 0; i < NUM_FX; i++)
              fx_wr_en[i] <= (dec.num == CAP_NUMW'(i));
          end else begin
            for (int i = 0; i < NUM_GP; i++)
              gp_wr_en[i] <= (dec.num == CAP_NUMW'(i));
          end
        end
      end
    end
  end
endmodule

// File: rtl/ctr_access_port_chk.sv
module ctr_access_port_chk #(
  parameter int NUM_GP = 4,
  parameter int NUM_FX = 3,
  parameter int GP_W   = 48,
  parameter int FX_W   = 40
) (
  input logic                clk,
  input logic                rst,
  input logic                req_valid,
  input logic                req_write,
  input logic                req_by_index,
  input logic [7:0]          req_addr,
  input logic [31:0]         req_index,
  input logic [63:0]         req_wdata,
  input logic [NUM_GP-1:0]   gp_wr_en,
  input logic [NUM_FX-1:0]   fx_wr_en,
  input logic [63:0]         wr_data,
  input logic                rd_valid,
  input logic [63:0]         rd_data,
  input logic                fault
);
  localparam logic [63:0] GPM = (GP_W >= 64) ? '1 : ((64'd1 << GP_W) - 64'd1);
  localparam logic [63:0] FXM = (FX_W >= 64) ? '1 : ((64'd1 << FX_W) - 64'd1);

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({gp_wr_en, fx_wr_en})); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rd_valid && gp_wr_en == '0 && fx_wr_en == '0 && !fault)); // R9
  AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (rst)
    fault |-> (gp_wr_en == '0 && fx_wr_en == '0 && !rd_valid && rd_data == '0)); // R8
  AST_GP_FITS: assert property (@(posedge clk) disable iff (rst)
    (|gp_wr_en) |-> ((wr_data & ~GPM) == '0)); // R2
  AST_FX_FITS: assert property (@(posedge clk) disable iff (rst)
    (|fx_wr_en) |-> ((wr_data & ~FXM) == '0)); // R5
  AST_WIDE_FAULT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_addr[7:6] == 2'b01 && |(req_wdata & ~GPM))
      |=> (fault && gp_wr_en == '0)); // R3
  AST_LEG_SEXT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_addr[7:6] == 2'b00 && req_addr[5:0] < 6'(NUM_GP))
      |=> (wr_data[31:0] == $past(req_wdata[31:0]) &&
           wr_data[GP_W-1] == $past(req_wdata[31]))); // R1
  AST_FAST_ZEXT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && req_by_index && req_index[31])
      |=> (rd_data[63:32] == 32'd0)); // R7
endmodule

bind ctr_access_port ctr_access_port_chk #(
  .NUM_GP(NUM_GP), .NUM_FX(NUM_FX), .GP_W(GP_W), .FX_W(FX_W)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .req_by_index(req_by_index), .req_addr(req_addr), .req_index(req_index),
  .req_wdata(req_wdata), .gp_wr_en(gp_wr_en), .fx_wr_en(fx_wr_en),
  .wr_data(wr_data), .rd_valid(rd_valid), .rd_data(rd_data), .fault(fault)
);

// File: tb/ctr_access_port_test.sv
module ctr_access_port_test;
  localparam int NGP = 4, NFX = 3, GW = 48, FW = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, req_by_index = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_index = '0;
  logic [63:0] req_wdata = '0;
  logic [NGP*GW-1:0] gp_values;
  logic [NFX*FW-1:0] fx_values;
  logic [NGP-1:0] gp_wr_en;
  logic [NFX-1:0] fx_wr_en;
  logic [63:0] wr_data, rd_data;
  logic rd_valid, fault;

  logic [63:0] gp_bank [NGP];
  logic [63:0] fx_bank [NFX];
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  for (genvar g = 0; g < NGP; g++) begin : g_gpv
    assign gp_values[g*GW +: GW] = gp_bank[g][GW-1:0];
  end
  for (genvar f = 0; f < NFX; f++) begin : g_fxv
    assign fx_values[f*FW +: FW] = fx_bank[f][FW-1:0];
  end

  ctr_access_port #(.NUM_GP(NGP), .NUM_FX(NFX), .GP_W(GW), .FX_W(FW)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_by_index(req_by_index), .req_addr(req_addr), .req_index(req_index),
    .req_wdata(req_wdata), .gp_values(gp_values), .fx_values(fx_values),
    .gp_wr_en(gp_wr_en), .fx_wr_en(fx_wr_en), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .fault(fault)
  );

  function automatic logic [63:0] msk(input logic [63:0] v, input int w);
    return (w >= 64) ? v : (v & ((64'd1 << w) - 64'd1));
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One request; outputs sampled at the negedge after the capturing posedge.
  task automatic issue(input logic wr, input logic byidx, input logic [7:0] addr,
                       input logic [31:0] idx, input logic [63:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_by_index = byidx;
    req_addr = addr; req_index = idx; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_by_index = 1'b0;
    for (int i = 0; i < NGP; i++) if (gp_wr_en[i]) gp_bank[i] = wr_data;
    for (int i = 0; i < NFX; i++) if (fx_wr_en[i]) fx_bank[i] = wr_data;
  endtask

  task automatic t_reset;
    chk("R10 strobes in reset", 64'({gp_wr_en, fx_wr_en}), 64'd0);
    chk("R10 flags in reset", {62'd0, rd_valid, fault}, 64'd0);
    chk("R10 data in reset", rd_data | wr_data, 64'd0);
  endtask

  task automatic t_legacy;
    issue(1'b1, 1'b0, 8'h00, '0, 64'hdead_beef_89ab_cdef);
    chk("R1 strobe", 64'(gp_wr_en), 64'd1);
    chk("R1 negative sign-extended", wr_data, 64'h0000_ffff_89ab_cdef);
    issue(1'b1, 1'b0, 8'h02, '0, 64'hffff_ffff_2345_6789);
    chk("R1 positive", wr_data, 64'h0000_0000_2345_6789);
  endtask

  task automatic t_full;
    issue(1'b1, 1'b0, 8'h41, '0, 64'h0000_ff01_2345_6789);
    chk("R2 strobe", 64'(gp_wr_en), 64'd2);
    chk("R2 data unchanged", wr_data, 64'h0000_ff01_2345_6789);
    chk("R2 no fault", 64'(fault), 64'd0);
  endtask

  task automatic t_wide_fault;
    issue(1'b1, 1'b0, 8'h41, '0, 64'hffff_ff01_2345_6789);
    chk("R3 fault", 64'(fault), 64'd1);
    chk("R3 no strobe", 64'({gp_wr_en, fx_wr_en}), 64'd0);
    issue(1'b0, 1'b0, 8'h41, '0, '0);
    chk("R3 counter unchanged", rd_data, 64'h0000_ff01_2345_6789);
  endtask

  task automatic t_alias_read;
    logic [63:0] a;
    issue(1'b0, 1'b0, 8'h00, '0, '0);
    a = rd_data;
    chk("R4 legacy alias read", a, msk(gp_bank[0], GW));
    issue(1'b0, 1'b0, 8'h40, '0, '0);
    chk("R4 full alias read matches", rd_data, a);
    chk("R4 rd_valid", 64'(rd_valid), 64'd1);
  endtask

  task automatic t_fixed;
    issue(1'b1, 1'b0, 8'h81, '0, 64'hffff_ff01_2345_6789);
    chk("R5 fixed strobe", 64'(fx_wr_en), 64'd2);
    chk("R5 fixed masked", wr_data, 64'h0000_0001_2345_6789);
    chk("R5 fixed no fault", 64'(fault), 64'd0);
    issue(1'b0, 1'b0, 8'h81, '0, '0);
    chk("R5 fixed read", rd_data, 64'h0000_0001_2345_6789);
  endtask

  task automatic t_index;
    issue(1'b0, 1'b1, 8'hff, 32'h0000_0001, '0);
    chk("R6 gp by index", rd_data, msk(gp_bank[1], GW));
    issue(1'b0, 1'b1, 8'hff, 32'h4000_0001, '0);
    chk("R6 fixed by index", rd_data, msk(fx_bank[1], FW));
  endtask

  task automatic t_fast;
    issue(1'b0, 1'b1, 8'h00, 32'h8000_0000, '0);
    chk("R7 fast gp", rd_data, {32'd0, gp_bank[0][31:0]});
    issue(1'b0, 1'b1, 8'h00, 32'hc000_0001, '0);
    chk("R7 fast fixed", rd_data, {32'd0, fx_bank[1][31:0]});
  endtask

  task automatic t_bad;
    issue(1'b0, 1'b1, 8'h00, 32'd64, '0);
    chk("R8 index 64 fault", {62'd0, fault, rd_valid}, 64'd2);
    chk("R8 index 64 data zero", rd_data, 64'd0);
    issue(1'b0, 1'b1, 8'h00, 32'h4000_0003, '0);
    chk("R8 fixed index 3 fault", 64'(fault), 64'd1);
    issue(1'b1, 1'b0, 8'h04, '0, 64'd5);
    chk("R8 write gp4 fault", {58'd0, gp_wr_en, fx_wr_en, fault}, 64'd1);
    issue(1'b0, 1'b0, 8'hc0, '0, '0);
    chk("R8 group 3 fault", {62'd0, fault, rd_valid}, 64'd2);
  endtask

  task automatic t_idle;
    @(negedge clk);
    @(negedge clk);
    chk("R9 idle quiet", {58'd0, gp_wr_en, fx_wr_en, rd_valid, fault}, 64'd0);
  endtask

  initial begin
    for (int i = 0; i < NGP; i++) gp_bank[i] = 64'h1111_0000 * 64'(i + 1);
    for (int i = 0; i < NFX; i++) fx_bank[i] = 64'h2222_0000 * 64'(i + 1);
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_legacy();
    t_full();
    t_wide_fault();
    t_alias_read();
    t_fixed();
    t_index();
    t_fast();
    t_bad();
    t_idle();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual expired expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule